// File: doc/BRIEF.md
# SDRAM Mode Register Burst Sequencer

This block sits beside a DDR3-style command bus and follows the commands issued on it. When it sees a mode register set command aimed at mode register 0, it keeps the burst length mode, the burst order, the CAS latency code, the write recovery code and the DLL reset, test mode and power-down exit bits. It turns the two latency codes into cycle counts, and it raises a sticky error flag whenever a mode register write carries an illegal or reserved value.

For each read or write command, the block takes the low three column bits as the starting column. It then produces the column offsets of the burst, one offset per clock, and flags the final beat. The burst is 4 or 8 beats long. Mode register 0 can fix that length, or it can let address bit 12 of each command choose it. The beat order is nibble-sequential or interleaved. A controller or a memory model uses these beats to order its data, and it reads the latency outputs to place that data in time.

Top module: `mr_burst_seq`

## Requirements
- R1: After synchronous reset, no beat is valid, cas_lat reads 5, wr_rec reads 5, cfg_err, dll_reset, test_mode and fast_exit are 0, and bursts are 8 beats long in sequential order.
- R2: A command is a mode register set when cs_n, ras_n, cas_n and we_n are all low at a clock edge. Only ba = 000 updates the stored mode register 0, and the outputs show the new value from the next cycle. Mode register sets to ba 001, 010 or 011 leave every output unchanged.
- R3: The CAS latency code is {addr[6:4], addr[2]}. Codes 0010, 0100, 0110, 1000, 1010, 1100 and 1110 give cas_lat 5 through 11. Codes 0001, 0011 and 0101 give 12, 13 and 14. Every other code is reserved and gives cas_lat 0.
- R4: The write recovery code addr[11:9] maps 1 to 7 onto wr_rec 5, 6, 7, 8, 10, 12 and 14. Code 0 is reserved and gives wr_rec 0.
- R5: dll_reset follows addr[8], test_mode follows addr[7] and fast_exit follows addr[12] of the last mode register 0 write.
- R6: cfg_err is set and stays set until reset by any of these: a mode register set with addr[14:13] nonzero; a mode register set with ba[2] = 1, which is otherwise ignored; or a mode register 0 write whose burst length code, CAS latency code or write recovery code is reserved. Mode register 0 fields are still stored in the last case.
- R7: Burst length mode addr[1:0] works as follows. 00 gives 8 beats. 10 gives 4 beats. 01 takes the length from addr[12] of each read or write (1 gives 8, 0 gives 4). The reserved code 11 gives 8 beats.
- R8: With addr[3] = 0 (sequential), beat i has offset bits [1:0] = (start[1:0] + i) mod 4 and offset bit 2 = start[2] XOR i[2].
- R9: With addr[3] = 1 (interleaved), beat i has offset start[2:0] XOR i.
- R10: A read (cs_n=0, ras_n=1, cas_n=0, we_n=1) or write (we_n=0) produces beat 0 in the cycle after it is sampled. beat_last marks the final beat. A command is taken only while idle or on a last beat, so back-to-back bursts leave no gap, and a command issued in the middle of a burst is dropped.
- R11: beat_write is 1 for every beat of a write burst and 0 for every beat of a read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (3) | Bank address; selects the mode register during a set |
| addr | input | ADDR_W (15) | Address bus; mode register data or command column |
| beat_valid | output | 1 | A burst beat is present |
| beat_col | output | 3 | Column offset of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| beat_write | output | 1 | Current burst is a write |
| cas_lat | output | 4 | Decoded CAS latency in cycles, 0 if reserved |
| wr_rec | output | 4 | Decoded write recovery in cycles, 0 if reserved |
| dll_reset | output | 1 | Stored DLL reset request |
| test_mode | output | 1 | Stored test mode bit |
| fast_exit | output | 1 | Stored power-down exit choice, 1 = fast with DLL on |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
A mode field captured wrongly shows up on cas_lat, wr_rec or the flag outputs in the cycle right after the mode register set. A wrong burst order or length shows up on beat_col or beat_last in the first beat that depends on it. A wrong beat counter or acceptance rule shows up as a beat_last in the wrong cycle, a missing first beat of a chained burst, or a command that was taken in the middle of a burst and changes beat_col on the next beat. A sticky flag that fails to hold is caught by a legal write issued after an illegal one.

// File: rtl/mrbs_pkg.sv
package mrbs_pkg;

    localparam int LAT_W   = 4;
    localparam int COL_W   = 3;
    localparam int BEATS_L = 8;
    localparam int BEATS_S = 4;

    typedef enum logic [1:0] {
        BLM_FIX8 = 2'b00,
        BLM_OTF  = 2'b01,
        BLM_FIX4 = 2'b10,
        BLM_RSVD = 2'b11
    } blen_mode_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } burst_ord_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_MRS,
        CMD_RD,
        CMD_WR
    } cmd_e;

    typedef struct packed {
        blen_mode_e bl;
        burst_ord_e ord;
        logic [3:0] cl_code;
        logic       test_mode;
        logic       dll_rst;
        logic [2:0] wr_code;
        logic       fast_exit;
    } mr0_t;

    typedef struct packed {
        logic             active;
        logic             is_wr;
        logic             len8;
        burst_ord_e       ord;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] idx;
    } burst_t;

    localparam mr0_t MR0_RESET = '{
        bl:        BLM_FIX8,
        ord:       ORD_SEQ,
        cl_code:   4'b0010,
        test_mode: 1'b0,
        dll_rst:   1'b0,
        wr_code:   3'b001,
        fast_exit: 1'b0
    };

    // Latency code {A6:A4,A2}: even codes run 5..11, odd codes 12..14.
    function automatic logic [LAT_W-1:0] cl_cycles(input logic [3:0] code);
        logic [LAT_W-1:0] hi;
        hi = LAT_W'(code[3:1]);
        if (!code[0])
            return (hi == '0) ? '0 : hi + LAT_W'(4);
        else
            return (hi <= LAT_W'(2)) ? hi + LAT_W'(12) : '0;
    endfunction

    function automatic logic [LAT_W-1:0] wr_cycles(input logic [2:0] code);
        logic [LAT_W-1:0] c;
        c = LAT_W'(code);
        if (c == '0)
            return '0;
        else if (c <= LAT_W'(4))
            return c + LAT_W'(4);
        else
            return c << 1;
    endfunction

    function automatic logic mr0_reserved(input mr0_t m);
        return (m.bl == BLM_RSVD) || (cl_cycles(m.cl_code) == '0) ||
               (m.wr_code == 3'b000);
    endfunction

    function automatic logic [COL_W-1:0] beat_offset(input burst_ord_e ord,
                                                     input logic [COL_W-1:0] start,
                                                     input logic [COL_W-1:0] idx);
        logic [1:0] low;
        if (ord == ORD_ILV)
            return start ^ idx;
        low = start[1:0] + idx[1:0];
        return {start[2] ^ idx[2], low};
    endfunction

endpackage

// File: rtl/mrbs_cmd_decode.sv
module mrbs_cmd_decode
    import mrbs_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/mrbs_mode_reg.sv
module mrbs_mode_reg
    import mrbs_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BA_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output mr0_t              mr0,
    output logic              err
);
    localparam int HI_LSB = 13;

    logic is_mrs;
    logic high_bits_bad;
    logic bank_hi_bad;
    logic sel_mr0;
    mr0_t incoming;

    assign is_mrs        = (cmd == CMD_MRS);
    assign high_bits_bad = |addr[ADDR_W-1:HI_LSB];
    assign bank_hi_bad   = |ba[BA_W-1:2];
    assign sel_mr0       = is_mrs && !bank_hi_bad && (ba[1:0] == 2'b00);

    always_comb begin
        incoming.bl        = blen_mode_e'(addr[1:0]);
        incoming.ord       = burst_ord_e'(addr[3]);
        incoming.cl_code   = {addr[6:4], addr[2]};
        incoming.test_mode = addr[7];
        incoming.dll_rst   = addr[8];
        incoming.wr_code   = addr[11:9];
        incoming.fast_exit = addr[12];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mr0 <= MR0_RESET;
            err <= 1'b0;
        end else begin
            if (sel_mr0)
                mr0 <= incoming;
            if (is_mrs && (high_bits_bad || bank_hi_bad ||
                           (sel_mr0 && mr0_reserved(incoming))))
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/mrbs_beat_gen.sv
module mrbs_beat_gen
    import mrbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic             chop_n,
    input  logic [COL_W-1:0] start_col,
    input  blen_mode_e       bl_mode,
    input  burst_ord_e       ord,
    output logic             valid,
    output logic [COL_W-1:0] col,
    output logic             last,
    output logic             is_wr
);
    burst_t st;
    logic   accept;
    logic   want_len8;
    logic [COL_W-1:0] final_idx;

    assign final_idx = st.len8 ? COL_W'(BEATS_L - 1) : COL_W'(BEATS_S - 1);
    assign last      = st.active && (st.idx == final_idx);
    assign accept    = ((cmd == CMD_RD) || (cmd == CMD_WR)) && (!st.active || last);

    always_comb begin
        unique case (bl_mode)
            BLM_FIX4: want_len8 = 1'b0;
            BLM_OTF:  want_len8 = chop_n;
            default:  want_len8 = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (accept) begin
            st.active <= 1'b1;
            st.is_wr  <= (cmd == CMD_WR);
            st.len8   <= want_len8;
            st.ord    <= ord;
            st.start  <= start_col;
            st.idx    <= '0;
        end else if (st.active) begin
            if (last)
                st.active <= 1'b0;
            else
                st.idx <= st.idx + COL_W'(1);
        end
    end

    assign valid = st.active;
    assign is_wr = st.active && st.is_wr;
    assign col   = st.active ? beat_offset(st.ord, st.start, st.idx) : '0;
endmodule

// File: rtl/mr_burst_seq.sv
module mr_burst_seq
    import mrbs_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BA_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_last,
    output logic              beat_write,
    output logic [LAT_W-1:0]  cas_lat,
    output logic [LAT_W-1:0]  wr_rec,
    output logic              dll_reset,
    output logic              test_mode,
    output logic              fast_exit,
    output logic              cfg_err
);
    localparam int CHOP_BIT = 12;

    cmd_e cmd;
    mr0_t mr0;

    mrbs_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    mrbs_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mr (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .ba   (ba),
        .addr (addr),
        .mr0  (mr0),
        .err  (cfg_err)
    );

    mrbs_beat_gen u_beat (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .chop_n    (addr[CHOP_BIT]),
        .start_col (addr[COL_W-1:0]),
        .bl_mode   (mr0.bl),
        .ord       (mr0.ord),
        .valid     (beat_valid),
        .col       (beat_col),
        .last      (beat_last),
        .is_wr     (beat_write)
    );

    assign cas_lat   = cl_cycles(mr0.cl_code);
    assign wr_rec    = wr_cycles(mr0.wr_code);
    assign dll_reset = mr0.dll_rst;
    assign test_mode = mr0.test_mode;
    assign fast_exit = mr0.fast_exit;
endmodule

// File: rtl/mrbs_checker.sv
module mrbs_checker
    import mrbs_pkg::*;
#(
    parameter int BA_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [BA_W-1:0]  ba,
    input logic             beat_valid,
    input logic             beat_last,
    input logic             beat_write,
    input logic [LAT_W-1:0] cas_lat,
    input logic [LAT_W-1:0] wr_rec,
    input logic             cfg_err
);
    logic [COL_W-1:0] seen;
    logic             mr0_write;

    assign mr0_write = !cs_n && !ras_n && !cas_n && !we_n && (ba == '0);

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (beat_valid)
            seen <= beat_last ? '0 : seen + COL_W'(1);
    end

    assert_last_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

    assert_burst_continues_R10: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> beat_valid);

    assert_last_on_length_R7: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> (seen == 3'd3 || seen == 3'd7));

    assert_eight_max_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && seen == 3'd7) |-> beat_last);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_cl_range_R3: assert property (@(posedge clk) disable iff (rst)
        (cas_lat == '0) || (cas_lat >= 4'd5 && cas_lat <= 4'd14));

    assert_wr_range_R4: assert property (@(posedge clk) disable iff (rst)
        wr_rec inside {4'd0, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd12, 4'd14});

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (rst)
        !mr0_write |=> ($stable(cas_lat) && $stable(wr_rec)));

    assert_dir_held_R11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> $stable(beat_write));
endmodule

bind mr_burst_seq mrbs_checker #(.BA_W(BA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .beat_write (beat_write),
    .cas_lat    (cas_lat),
    .wr_rec     (wr_rec),
    .cfg_err    (cfg_err)
);

// File: tb/mr_burst_seq_tb.sv
module mr_burst_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [14:0] addr;
    logic        beat_valid, beat_last, beat_write;
    logic [2:0]  beat_col;
    logic [3:0]  cas_lat, wr_rec;
    logic        dll_reset, test_mode, fast_exit, cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the stored mode
    int m_bl, m_ord, m_cl, m_wr, m_dll, m_tm, m_fe;

    always #10 clk = ~clk;

    mr_burst_seq u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .beat_valid(beat_valid),
        .beat_col(beat_col), .beat_last(beat_last), .beat_write(beat_write),
        .cas_lat(cas_lat), .wr_rec(wr_rec), .dll_reset(dll_reset),
        .test_mode(test_mode), .fast_exit(fast_exit), .cfg_err(cfg_err)
    );

    function automatic int exp_cl(input int code);
        case (code)
            2: return 5;   4: return 6;   6: return 7;   8: return 8;
            10: return 9;  12: return 10; 14: return 11;
            1: return 12;  3: return 13;  5: return 14;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_wr(input int code);
        int t[8] = '{0, 5, 6, 7, 8, 10, 12, 14};
        return t[code];
    endfunction

    function automatic int exp_col(input int ord, input int st, input int i);
        if (ord == 1) return st ^ i;
        return ((st % 4 + i) % 4) + 4 * (((st / 4) + (i / 4)) % 2);
    endfunction

    function automatic int exp_len(input int bl, input int a12);
        if (bl == 2) return 4;
        if (bl == 1) return a12 ? 8 : 4;
        return 8;
    endfunction

    function automatic logic [14:0] mk_mr0(input int bl, ord, cl, wr, dll, tm, fe);
        logic [14:0] a = '0;
        a[1:0]  = 2'(bl);
        a[2]    = cl[0];
        a[3]    = ord[0];
        a[6:4]  = 3'(cl >> 1);
        a[7]    = tm[0];
        a[8]    = dll[0];
        a[11:9] = 3'(wr);
        a[12]   = fe[0];
        return a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_nop();
        cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = '0; addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bus_nop();
        repeat (2) @(negedge clk);
        rst = 0;
        m_bl = 0; m_ord = 0; m_cl = 2; m_wr = 1; m_dll = 0; m_tm = 0; m_fe = 0;
    endtask

    task automatic mrs(input logic [2:0] b, input logic [14:0] a);
        @(negedge clk);
        cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = b; addr = a;
        @(negedge clk);
        bus_nop();
    endtask

    task automatic set_mr0(input int bl, ord, cl, wr, dll, tm, fe);
        mrs(3'b000, mk_mr0(bl, ord, cl, wr, dll, tm, fe));
        m_bl = bl; m_ord = ord; m_cl = cl; m_wr = wr; m_dll = dll; m_tm = tm; m_fe = fe;
    endtask

    task automatic check_mode(input string req);
        check({req, " cas_lat"}, cas_lat, exp_cl(m_cl));
        check({req, " wr_rec"}, wr_rec, exp_wr(m_wr));
        check({req, " flags"}, {dll_reset, test_mode, fast_exit},
              {m_dll[0], m_tm[0], m_fe[0]});
    endtask

    task automatic drive_cmd(input bit wr, input bit a12, input int st);
        cs_n = 0; ras_n = 1; cas_n = 0; we_n = !wr; ba = '0;
        addr = '0; addr[12] = a12; addr[2:0] = 3'(st);
    endtask

    task automatic expect_beat(input string req, input int i, input int len,
                               input int ord, input int st, input bit wr);
        check(req, {beat_valid, beat_last, beat_write, beat_col},
              {1'b1, (i == len - 1), wr, 3'(exp_col(ord, st, i))});
    endtask

    task automatic burst(input string req, input bit wr, input bit a12, input int st);
        int len = exp_len(m_bl, a12);
        @(negedge clk);
        drive_cmd(wr, a12, st);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            bus_nop();
            expect_beat(req, i, len, m_ord, st, wr);
        end
        @(negedge clk);
        check({req, " idle after last"}, beat_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; bus_nop();
        do_reset();

        // R1 reset state
        check("R1 valid", beat_valid, 0);
        check("R1 err", cfg_err, 0);
        check_mode("R1");
        burst("R1 default BL8 seq", 0, 0, 5);

        // R3 every legal latency code, R4 every write recovery code
        for (int k = 0; k < 10; k++) begin
            int code = (k < 7) ? 2 * (k + 1) : 2 * (k - 7) + 1;
            set_mr0(0, 0, code, (k % 7) + 1, 0, 0, 0);
            check_mode("R3 R4 decode");
        end
        // R5 flags
        set_mr0(0, 0, 4, 3, 1, 0, 1);
        check_mode("R5 dll/fast");
        set_mr0(0, 0, 4, 3, 0, 1, 0);
        check_mode("R5 test");
        check("R6 legal no err", cfg_err, 0);

        // R2 other mode registers ignored
        mrs(3'b001, mk_mr0(2, 1, 1, 7, 1, 1, 1));
        mrs(3'b010, mk_mr0(2, 1, 12, 6, 1, 0, 1));
        mrs(3'b011, 15'h0fff);
        check_mode("R2 MR1-3 ignored");
        check("R2 no err", cfg_err, 0);
        burst("R2 order unchanged", 1, 0, 2);

        // R7 lengths, R8 sequential, R9 interleaved
        set_mr0(2, 0, 2, 1, 0, 0, 0);
        burst("R7 fixed BC4 R8", 0, 1, 7);
        set_mr0(1, 1, 2, 1, 0, 0, 0);
        burst("R7 otf BC4 R9", 1, 0, 6);
        burst("R7 otf BL8 R9", 0, 1, 3);
        set_mr0(1, 0, 2, 1, 0, 0, 0);
        burst("R7 otf BL8 R8", 1, 1, 6);

        // R10 mid-burst command dropped (fixed BL8 sequential, start 1)
        set_mr0(0, 0, 2, 1, 0, 0, 0);
        @(negedge clk); drive_cmd(0, 1, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_nop();
            expect_beat("R10 drop mid-burst", i, 8, 0, 1, 0);
            if (i == 2) drive_cmd(1, 1, 4);
        end
        @(negedge clk);
        check("R10 dropped cmd leaves idle", beat_valid, 0);

        // R10 back-to-back on last beat, R11 direction follows command
        set_mr0(1, 1, 2, 1, 0, 0, 0);
        @(negedge clk); drive_cmd(0, 0, 6);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bus_nop();
            expect_beat("R10 chain first R11", i, 4, 1, 6, 0);
            if (i == 3) drive_cmd(1, 1, 3);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_nop();
            expect_beat("R10 chain second R11", i, 8, 1, 3, 1);
        end
        @(negedge clk);
        check("R10 chain idle", beat_valid, 0);

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            int k  = $urandom_range(0, 9);
            int cl = (k < 7) ? 2 * (k + 1) : 2 * (k - 7) + 1;
            set_mr0($urandom_range(0, 2), $urandom_range(0, 1), cl,
                    $urandom_range(1, 7), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 1));
            check_mode("R3 R4 R5 random");
            for (int b = 0; b < 3; b++)
                burst("R7 R8 R9 R11 random", 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), $urandom_range(0, 7));
        end
        check("R6 no err after legal traffic", cfg_err, 0);

        // R6 error cases
        do_reset();
        mrs(3'b000, mk_mr0(0, 0, 6, 2, 0, 0, 0) | 15'h2000);
        m_cl = 6; m_wr = 2;
        check("R6 A13 set", cfg_err, 1);
        check_mode("R6 fields stored");
        set_mr0(0, 0, 2, 1, 0, 0, 0);
        check("R6 sticky", cfg_err, 1);

        do_reset();
        mrs(3'b100, mk_mr0(0, 0, 12, 7, 1, 1, 1));
        check("R6 BA2 err", cfg_err, 1);
        check_mode("R6 BA2 ignored");

        do_reset();
        set_mr0(0, 0, 0, 1, 0, 0, 0);
        check("R6 CL reserved err", cfg_err, 1);
        check("R3 reserved cl", cas_lat, 0);

        do_reset();
        set_mr0(0, 0, 7, 1, 0, 0, 0);
        check("R6 CL 0111 err", cfg_err, 1);
        check("R3 reserved 0111", cas_lat, 0);

        do_reset();
        set_mr0(0, 0, 2, 0, 0, 0, 0);
        check("R6 WR reserved err", cfg_err, 1);
        check("R4 reserved wr", wr_rec, 0);

        do_reset();
        set_mr0(3, 0, 2, 1, 0, 0, 0);
        check("R6 BL reserved err", cfg_err, 1);
        burst("R7 reserved BL gives 8", 0, 0, 4);

        do_reset();
        check("R1 err cleared by reset", cfg_err, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule